// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is the bus-facing half of a byte-addressed serial memory. It watches a two-wire bus (clock line and open-drain data line), finds START, STOP and repeated START conditions, and answers only to its own 7-bit device address. Behind it sits a 4096-byte synchronous memory that can be written and read one byte after another.

A single address counter decides every access. A write sends two address bytes and may follow them with data bytes. A write that carries no data ("dummy" write) loads the counter only. A repeated START with the read bit set then returns data from that location. A read with no address phase continues from wherever the last access left the counter. While the master acknowledges, the slave keeps sending the next byte, and the counter rolls over from the top of the array to zero. Both bus lines are sampled by the system clock through two-flop synchronizers. The system clock must run at least eight times faster than the bus clock.

Top module: `i2c_mem_slave`

## Requirements
- R1: The slave acknowledges (drives SDA low in the ninth clock) only a device address byte whose upper seven bits equal DEV_ADDR (default 7'h50, so bytes 0xA0 for write and 0xA1 for read). A non-matching address gets no acknowledge, and SDA stays released for the rest of that transfer until the next START.
- R2: Random read: START, device address with bit 0 = 0, high address byte, low address byte, repeated START, device address with bit 0 = 1. The slave acknowledges each byte and then returns the byte stored at the loaded address, MSB first.
- R3: In the high address byte only bits 3:0 are used. Bits 7:4 are ignored, so 0xF0 0x11 selects location 0x011.
- R4: A read with no address phase returns the byte at the last accessed address plus one.
- R5: Each data byte written after the two address bytes is stored at the counter and acknowledged, and the counter then points one past it. A read that follows therefore starts after the last written byte.
- R6: When the master acknowledges a read byte, the slave sends the byte at the next address. Sequential reads of any length are possible.
- R7: The counter wraps from 4095 to 0 in both reads and writes.
- R8: After the master answers a byte with NACK, the slave leaves SDA released and returns to idle. It also releases SDA at any STOP.
- R9: The slave changes its SDA output only while SCL is low. It is released out of reset.
- R10: A STOP in the middle of a byte abandons the transfer and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 = pull the data line low; 0 = release it |

## Verification
The bench fills two regions of the memory with page writes: one near the bottom of the array and one that runs over the top and into location 0. It then reads them back in every mode. A random read with junk in the upper address bits shows that only twelve address bits are used. Repeated current-address reads after a read and after a one-byte write show which event moves the counter. Sequential reads across the top of the array show the wrap and the continue-on-ACK behaviour. A wrong device address and a STOP cut into the low address byte are each followed by a current-address read. That read shows whether either stimulus disturbed the counter or drew a response on the bus.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } byte_phase_t;

  function automatic byte_phase_t phase_after(input byte_phase_t ph);
    case (ph)
      PH_DEV:  return PH_AHI;
      PH_AHI:  return PH_ALO;
      default: return PH_DATA;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lines_i,
  output logic       sda_s,
  output logic       scl_rise,
  output logic       scl_fall,
  output logic       start_det,
  output logic       stop_det
);
  localparam int L_SCL = 0;
  localparam int L_SDA = 1;

  logic [1:0] lvl;
  logic [1:0] prev;

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], lines_i[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= lvl;
  end

  assign sda_s     = lvl[L_SDA];
  assign scl_rise  = lvl[L_SCL] & ~prev[L_SCL];
  assign scl_fall  = ~lvl[L_SCL] & prev[L_SCL];
  assign start_det = lvl[L_SCL] & prev[L_SCL] & prev[L_SDA] & ~lvl[L_SDA];
  assign stop_det  = lvl[L_SCL] & prev[L_SCL] & ~prev[L_SDA] & lvl[L_SDA];
endmodule

// File: rtl/i2c_byte_ram.sv
module i2c_byte_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] addr_cnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              sda_oe
);
  localparam int HI_W = ADDR_W - 8;

  bus_state_t  state;
  byte_phase_t phase;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic [7:0]  shout;
  logic [HI_W-1:0] hi_q;
  logic        rw_q;
  logic        mack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= PH_DEV;
      bitcnt    <= '0;
      shreg     <= '0;
      shout     <= '0;
      hi_q      <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      addr_cnt  <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      sda_oe    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_RX;
        phase  <= PH_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              state  <= ST_ACK;
              sda_oe <= 1'b1;
              case (phase)
                PH_DEV: begin
                  rw_q <= shreg[0];
                  if (shreg[7:1] != DEV_ADDR) begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                  end
                end
                PH_AHI: hi_q <= shreg[HI_W-1:0];
                PH_ALO: addr_cnt <= {hi_q, shreg};
                default: begin
                  mem_we    <= 1'b1;
                  mem_waddr <= addr_cnt;
                  mem_wdata <= shreg;
                  addr_cnt  <= addr_cnt + ADDR_W'(1);
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (phase == PH_DEV && rw_q) begin
                state  <= ST_TX;
                shout  <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state  <= ST_RX;
                phase  <= phase_after(phase);
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                state    <= ST_MACK;
                sda_oe   <= 1'b0;
                addr_cnt <= addr_cnt + ADDR_W'(1);
              end else begin
                bitcnt <= bitcnt + 4'd1;
                shout  <= {shout[6:0], 1'b0};
                sda_oe <= ~shout[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                state  <= ST_TX;
                bitcnt <= '0;
                shout  <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int         ADDR_W      = 12,
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] addr_cnt;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .lines_i   ({sda_i, scl_i}),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_byte_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (addr_cnt),
    .rdata (rd_data)
  );

  i2c_mem_ctrl #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .addr_cnt  (addr_cnt),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .sda_oe    (sda_oe)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_det,
  input logic              stop_det,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [ADDR_W-1:0] addr_cnt
);
  // R9: output only moves while the bus clock is low
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R8: a STOP always leaves the data line released
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R1: a START returns the slave to listening, line released
  a_r1_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R5: after a stored byte the counter points one past it
  a_r5_write_moves_counter: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> addr_cnt == mem_waddr + ADDR_W'(1));

  // R5: the counter holds still while the stored byte is written
  a_r5_counter_steady_after_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(addr_cnt));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .addr_cnt  (addr_cnt)
);

// File: tb/i2c_mem_slave_tb_top.sv
module i2c_mem_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam logic [7:0] DEV_W = 8'hA0;
  localparam logic [7:0] DEV_R = 8'hA1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_slave dut_i (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_m),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wait_clk(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_rstart();
    wait_clk(Q); sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1;
    wait_clk(2*Q); sda_m = 1'b0; wait_clk(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(Q); sda_m = 1'b0; wait_clk(Q); scl_m = 1'b1;
    wait_clk(2*Q); sda_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic put_bit(input logic b);
    wait_clk(Q); sda_m = b; wait_clk(Q); scl_m = 1'b1;
    wait_clk(2*Q); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_clk(2*Q); scl_m = 1'b1;
    wait_clk(Q); b = sda_bus; wait_clk(Q); scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~give_ack);
  endtask

  task automatic addr_phase(input string req, input logic [15:0] a);
    logic ak;
    bus_start();
    put_byte(DEV_W, ak);  chk({req, " dev-w ack"}, {7'd0, ak}, 8'd1);
    put_byte(a[15:8], ak); chk({req, " addr-hi ack"}, {7'd0, ak}, 8'd1);
    put_byte(a[7:0], ak);  chk({req, " addr-lo ack"}, {7'd0, ak}, 8'd1);
  endtask

  task automatic read_burst(input string req, input logic [7:0] exp[4], input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      get_byte(d, i != n-1);
      chk({req, " read data"}, d, exp[i]);
    end
    wait_clk(2);
    chk("R8 released after NACK", {7'd0, sda_oe}, 8'd0);
    bus_stop();
    chk("R8 released after STOP", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic cur_read(input string req, input logic [7:0] exp);
    logic ak;
    logic [7:0] e[4];
    e = '{exp, 8'h00, 8'h00, 8'h00};
    bus_start();
    put_byte(DEV_R, ak); chk({req, " dev-r ack"}, {7'd0, ak}, 8'd1);
    read_burst(req, e, 1);
  endtask

  task automatic page_write(input string req, input logic [15:0] a, input logic [7:0] d[4], input int n);
    logic ak;
    addr_phase(req, a);
    for (int i = 0; i < n; i++) begin
      put_byte(d[i], ak); chk({req, " data ack"}, {7'd0, ak}, 8'd1);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    wait_clk(4); rst = 1'b0; wait_clk(4);
    chk("R9 released out of reset", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_fill();
    page_write("R5 fill low", 16'h0010, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, 4);
    page_write("R5 fill low2", 16'h0014, '{8'hA4, 8'hA5, 8'h00, 8'h00}, 2);
    page_write("R7 fill wrap", 16'h0FFE, '{8'h5E, 8'h5F, 8'h60, 8'h61}, 4);
  endtask

  task automatic t_random_read();
    logic ak;
    addr_phase("R3", 16'hF011);
    bus_rstart();
    put_byte(DEV_R, ak); chk("R2 dev-r ack", {7'd0, ak}, 8'd1);
    read_burst("R2 R3 random", '{8'hA1, 8'h00, 8'h00, 8'h00}, 1);
  endtask

  task automatic t_current_read();
    cur_read("R4 first", 8'hA2);
    cur_read("R4 second", 8'hA3);
  endtask

  task automatic t_write_hook();
    page_write("R5 single", 16'h000F, '{8'h99, 8'h00, 8'h00, 8'h00}, 1);
    cur_read("R5 after write", 8'hA0);
  endtask

  task automatic t_seq_read();
    logic ak;
    addr_phase("R6", 16'h0010);
    bus_rstart();
    put_byte(DEV_R, ak); chk("R6 dev-r ack", {7'd0, ak}, 8'd1);
    read_burst("R6 sequential", '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, 4);
  endtask

  task automatic t_mismatch();
    logic ak;
    logic [7:0] d;
    bus_start();
    put_byte(8'h46, ak); chk("R1 wrong addr write no ack", {7'd0, ak}, 8'd0);
    put_byte(8'h00, ak); chk("R1 later byte no ack", {7'd0, ak}, 8'd0);
    bus_stop();
    bus_start();
    put_byte(8'h47, ak); chk("R1 wrong addr read no ack", {7'd0, ak}, 8'd0);
    get_byte(d, 1'b0);   chk("R1 bus undriven", d, 8'hFF);
    bus_stop();
    cur_read("R1 counter kept", 8'hA4);
  endtask

  task automatic t_abandon();
    logic ak;
    bus_start();
    put_byte(DEV_W, ak);  chk("R10 dev-w ack", {7'd0, ak}, 8'd1);
    put_byte(8'h00, ak);  chk("R10 addr-hi ack", {7'd0, ak}, 8'd1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    cur_read("R10 counter kept", 8'hA5);
  endtask

  task automatic t_wrap();
    logic ak;
    addr_phase("R7", 16'h0FFE);
    bus_rstart();
    put_byte(DEV_R, ak); chk("R7 dev-r ack", {7'd0, ak}, 8'd1);
    read_burst("R7 wrap", '{8'h5E, 8'h5F, 8'h60, 8'h61}, 4);
    cur_read("R7 after wrap", 8'hC3);
  endtask

  task automatic t_wrap_seed();
    page_write("R7 seed", 16'h0002, '{8'hC3, 8'h00, 8'h00, 8'h00}, 1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_fill();
    t_random_read();
    t_current_read();
    t_write_hook();
    t_seq_read();
    t_mismatch();
    t_abandon();
    t_wrap_seed();
    t_wrap();
    wait_clk(10);
    report();
  end

  initial begin
    wait_clk(150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end
endmodule